// File: doc/BRIEF.md
# Per-Pin Event Detector with Interrupt and DMA Routing

This block watches a bank of general-purpose input pins and turns chosen pin activity into requests. Each pin owns one 32-bit control word on a simple register port. A 4-bit event-selection field in that word picks one of three things for the pin: do nothing, raise a DMA request on an edge, or raise an interrupt on an edge or while the pin is held low. A detected event sets a sticky per-pin flag, which is visible in the same word.

An interrupt-routed flag stays set until software writes a one to it. A DMA-routed flag is cleared by that pin's DMA-completion strobe, and software can also clear it by writing a one. All pin-routed interrupt flags are ORed onto one interrupt line. Each DMA-routed flag drives its own request line. The low 16 bits of every word are plain storage, with no effect on detection. Pin inputs are brought through a two-stage synchronizer before any edge or level is judged.

Top module: `pin_evt_ctrl`

## Requirements
- R1: After synchronous reset every control word reads 0, `irq` is 0 and `dma_req` is all zeros.
- R2: The word for pin n is at byte address 4*n, and address bits [1:0] are ignored. Bits [31:25] and [23:20] always read 0. Bits [19:16] (event selection) and bits [15:0] (plain storage) read back as written.
- R3: Selection 1001 sets the flag (bit 24) on a rising pin edge, 1010 on a falling edge and 1011 on either edge. While any interrupt-routed flag is set, `irq` is 1.
- R4: Selection 1000 sets the flag while the synchronized pin is 0. A write of one to the flag while the pin stays low leaves the flag reading 1. Once the pin is high, a write of one clears the flag and it stays clear.
- R5: A write with bit 24 = 1 clears that pin's flag. A write with bit 24 = 0 leaves the flag as it was.
- R6: Selections 0001, 0010 and 0011 (DMA on rising, falling and either edge) set the flag. While the flag is set, `dma_req[n]` is 1 and `irq` is not raised by that pin. A one-cycle `dma_done[n]` pulse clears the flag.
- R7: `dma_done[n]` has no effect on the flag of a pin whose selection is interrupt-routed.
- R8: Selections 0000, 0100 through 0111 and 1100 through 1111 never set the flag.
- R9: If an event and a clear arrive in the same cycle, the flag ends up set.
- R10: A pin change driven just after a clock edge is visible in the flag after the third following rising edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| bus_addr | input | ADDR_W | Byte address of a control word |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read of the addressed word |
| dma_done | input | NUM_PINS | Per-pin DMA completion strobes |
| irq | output | 1 | OR of set flags on interrupt-routed pins |
| dma_req | output | NUM_PINS | Per-pin DMA request (flag of a DMA-routed pin) |

## Verification
A wrong synchronizer or edge register moves the flag's appearance by one cycle or creates phantom edges. The bench catches this by reading the word at exactly the second and third edge after a pin change. A wrong routing decode shows at once on `irq` or `dma_req` in the cycle after the flag sets. A lost or wrongly scoped clear leaves a flag reading 1 in the word read on the cycle right after the write or `dma_done` pulse.

// File: rtl/pin_evt_pkg.sv
package pin_evt_pkg;

    localparam int WORD_W   = 32;
    localparam int FLAG_BIT = 24;
    localparam int SEL_LSB  = 16;
    localparam int SEL_W    = 4;
    localparam int STORE_W  = 16;

    typedef enum logic [1:0] {
        ROUTE_OFF,
        ROUTE_DMA,
        ROUTE_IRQ
    } route_e;

    typedef enum logic [1:0] {
        TRIG_LOW,
        TRIG_RISE,
        TRIG_FALL,
        TRIG_ANY
    } trig_e;

    typedef struct packed {
        route_e route;
        trig_e  trig;
    } evt_sel_t;

    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } pin_obs_t;

    function automatic evt_sel_t decode_sel(input logic [SEL_W-1:0] code);
        evt_sel_t d;
        d.route = ROUTE_OFF;
        d.trig  = TRIG_LOW;
        case (code)
            4'b0001: begin d.route = ROUTE_DMA; d.trig = TRIG_RISE; end
            4'b0010: begin d.route = ROUTE_DMA; d.trig = TRIG_FALL; end
            4'b0011: begin d.route = ROUTE_DMA; d.trig = TRIG_ANY;  end
            4'b1000: begin d.route = ROUTE_IRQ; d.trig = TRIG_LOW;  end
            4'b1001: begin d.route = ROUTE_IRQ; d.trig = TRIG_RISE; end
            4'b1010: begin d.route = ROUTE_IRQ; d.trig = TRIG_FALL; end
            4'b1011: begin d.route = ROUTE_IRQ; d.trig = TRIG_ANY;  end
            default: begin d.route = ROUTE_OFF; d.trig = TRIG_LOW;  end
        endcase
        return d;
    endfunction

    function automatic logic trig_hit(input trig_e t, input pin_obs_t o);
        case (t)
            TRIG_LOW:  return !o.lvl;
            TRIG_RISE: return o.rise;
            TRIG_FALL: return o.fall;
            default:   return o.rise | o.fall;
        endcase
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync
    import pin_evt_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_PINS-1:0]       pin_raw,
    output pin_obs_t [NUM_PINS-1:0]   obs
);

    logic [NUM_PINS-1:0] stage1, stage2, prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
            prev   <= '0;
        end else begin
            stage1 <= pin_raw;
            stage2 <= stage1;
            prev   <= stage2;
        end
    end

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_obs
        assign obs[g].lvl  = stage2[g];
        assign obs[g].rise = stage2[g] & ~prev[g];
        assign obs[g].fall = ~stage2[g] & prev[g];

        // R10: a new level in the second stage differs from the one-cycle-old copy
        p_edge_from_stage_r10: assert property (@(posedge clk) disable iff (rst)
            (stage2[g] != stage1[g]) |=> (obs[g].rise | obs[g].fall));
    end

endmodule

// File: rtl/pin_evt_cell.sv
module pin_evt_cell
    import pin_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  pin_obs_t          obs,
    input  logic              wr_sel,
    input  logic [WORD_W-1:0] wdata,
    input  logic              dma_done,
    output logic [WORD_W-1:0] rdata,
    output logic              irq_flag,
    output logic              dma_flag
);

    logic [SEL_W-1:0]   sel_q;
    logic [STORE_W-1:0] store_q;
    logic               flag_q;
    evt_sel_t           dec;
    logic               evt, w1c, dma_clr, flag_d;
    logic               unused_wbits;

    assign unused_wbits = ^{wdata[WORD_W-1:FLAG_BIT+1],
                            wdata[FLAG_BIT-1:SEL_LSB+SEL_W]};

    assign dec     = decode_sel(sel_q);
    assign evt     = (dec.route != ROUTE_OFF) && trig_hit(dec.trig, obs);
    assign w1c     = wr_sel && wdata[FLAG_BIT];
    assign dma_clr = (dec.route == ROUTE_DMA) && dma_done;
    assign flag_d  = evt | (flag_q & ~(w1c | dma_clr));

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= '0;
            store_q <= '0;
            flag_q  <= 1'b0;
        end else begin
            flag_q <= flag_d;
            if (wr_sel) begin
                sel_q   <= wdata[SEL_LSB +: SEL_W];
                store_q <= wdata[STORE_W-1:0];
            end
        end
    end

    always_comb begin
        rdata                     = '0;
        rdata[FLAG_BIT]           = flag_q;
        rdata[SEL_LSB +: SEL_W]   = sel_q;
        rdata[STORE_W-1:0]        = store_q;
    end

    assign irq_flag = flag_q && (dec.route == ROUTE_IRQ);
    assign dma_flag = flag_q && (dec.route == ROUTE_DMA);

    p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
        evt |=> flag_q);
    p_w1c_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (w1c && !evt) |=> !flag_q);
    p_w0_keeps_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_sel && !wdata[FLAG_BIT] && flag_q && !dma_clr) |=> flag_q);
    p_dma_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (dma_clr && !evt) |=> !flag_q);
    p_dma_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (flag_q && dma_done && dec.route == ROUTE_IRQ && !w1c) |=> flag_q);
    p_off_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (dec.route == ROUTE_OFF && !flag_q) |=> !flag_q);
    p_level_low_r4: assert property (@(posedge clk) disable iff (rst)
        (dec.route == ROUTE_IRQ && dec.trig == TRIG_LOW && !obs.lvl) |=> flag_q);

endmodule

// File: rtl/pin_evt_ctrl.sv
module pin_evt_ctrl
    import pin_evt_pkg::*;
#(
    parameter int NUM_PINS = 32,
    localparam int IDX_W  = $clog2(NUM_PINS),
    localparam int ADDR_W = IDX_W + 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] dma_done,
    output logic                irq,
    output logic [NUM_PINS-1:0] dma_req
);

    pin_obs_t [NUM_PINS-1:0] obs;
    logic [WORD_W-1:0]       cell_rd [NUM_PINS];
    logic [NUM_PINS-1:0]     irq_flags;
    logic [IDX_W-1:0]        idx;
    logic                    unused_lsb;

    assign idx        = bus_addr[ADDR_W-1:2];
    assign unused_lsb = ^bus_addr[1:0];

    pin_sync #(.NUM_PINS(NUM_PINS)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .pin_raw (pin_in),
        .obs     (obs)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_cell
        pin_evt_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .obs      (obs[i]),
            .wr_sel   (bus_we && (idx == IDX_W'(i))),
            .wdata    (bus_wdata),
            .dma_done (dma_done[i]),
            .rdata    (cell_rd[i]),
            .irq_flag (irq_flags[i]),
            .dma_flag (dma_req[i])
        );
    end

    assign bus_rdata = cell_rd[idx];
    assign irq       = |irq_flags;

    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata[31:25] == '0) && (bus_rdata[23:20] == '0));
    p_route_excl_r6: assert property (@(posedge clk) disable iff (rst)
        (irq_flags & dma_req) == '0);

endmodule

// File: tb/pin_evt_ctrl_test.sv
module pin_evt_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] pin_in = '0;
    logic [6:0]    bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] dma_done = '0;
    logic          irq;
    logic [NP-1:0] dma_req;

    always #(CLK_PERIOD/2) clk = ~clk;

    pin_evt_ctrl #(.NUM_PINS(NP)) uut (
        .clk(clk), .rst(rst), .pin_in(pin_in), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dma_done(dma_done), .irq(irq), .dma_req(dma_req)
    );

    typedef struct {
        string       req;
        int          sel;   // 0 irq, 1 dma_req vector, 2 read word
        logic [31:0] exp;
    } chk_t;

    chk_t q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // monitor: pops expectations and compares at the falling edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            chk_t it;
            logic [31:0] act;
            it = q.pop_front();
            case (it.sel)
                0:       act = {31'd0, irq};
                1:       act = dma_req;
                default: act = bus_rdata;
            endcase
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic push(input string req, input int sel, input logic [31:0] exp);
        chk_t it;
        it.req = req; it.sel = sel; it.exp = exp;
        q.push_back(it);
        wait (q.size() == 0);
    endtask

    task automatic read_exp(input string req, input int pin, input logic [31:0] exp);
        bus_addr = 7'(pin * 4);
        push(req, 2, exp);
    endtask

    task automatic wr(input logic [6:0] addr, input logic [31:0] data);
        bus_addr  = addr;
        bus_wdata = data;
        bus_we    = 1'b1;
        tick(1);
        bus_we    = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        // R1 reset state
        read_exp("R1 word0", 0, 32'h0);
        read_exp("R1 word31", 31, 32'h0);
        push("R1 irq", 0, 32'h0);
        push("R1 dma_req", 1, 32'h0);

        // R2 reserved bits, storage bits, address lsbs; R8 reserved selection 1111
        wr(7'(5*4), 32'hFFFF_FFFF);
        read_exp("R2 reserved zero", 5, 32'h000F_FFFF);
        pin_in[5] = 1'b1; tick(4);
        pin_in[5] = 1'b0; tick(4);
        read_exp("R8 sel 1111 quiet", 5, 32'h000F_FFFF);
        wr(7'(5*4+3), 32'h0004_0100);
        read_exp("R2 addr lsb ignored", 5, 32'h0004_0100);
        pin_in[5] = 1'b1; tick(4);
        pin_in[5] = 1'b0; tick(4);
        read_exp("R8 sel 0100 quiet", 5, 32'h0004_0100);
        wr(7'(5*4), 32'h0007_0000);
        pin_in[5] = 1'b1; tick(4);
        pin_in[5] = 1'b0; tick(4);
        read_exp("R8 sel 0111 quiet", 5, 32'h0007_0000);
        wr(7'(5*4), 32'h0000_0000);
        pin_in[5] = 1'b1; tick(4);
        read_exp("R8 sel 0000 quiet", 5, 32'h0);

        // R3 rising, R10 latency
        wr(7'(2*4), 32'h0009_0000);
        pin_in[2] = 1'b1; tick(2);
        read_exp("R10 not yet after 2 edges", 2, 32'h0009_0000);
        tick(1);
        read_exp("R10 R3 rise sets flag", 2, 32'h0109_0000);
        push("R3 irq high", 0, 32'h1);
        // R5 write one clears
        wr(7'(2*4), 32'h0109_0000);
        read_exp("R5 w1c clears", 2, 32'h0009_0000);
        push("R5 irq low", 0, 32'h0);
        // R3 falling, R5 write zero keeps
        wr(7'(2*4), 32'h000A_0000);
        pin_in[2] = 1'b0; tick(3);
        read_exp("R3 fall sets flag", 2, 32'h010A_0000);
        wr(7'(2*4), 32'h000A_0000);
        read_exp("R5 w0 keeps flag", 2, 32'h010A_0000);
        // R3 either edge
        wr(7'(2*4), 32'h010B_0000);
        read_exp("R5 w1c before any-edge", 2, 32'h000B_0000);
        pin_in[2] = 1'b1; tick(3);
        read_exp("R3 any-edge rise", 2, 32'h010B_0000);
        wr(7'(2*4), 32'h010B_0000);
        pin_in[2] = 1'b0; tick(3);
        read_exp("R3 any-edge fall", 2, 32'h010B_0000);
        wr(7'(2*4), 32'h010B_0000);

        // R4 level low, R9 set wins over clear
        wr(7'(3*4), 32'h0008_0000);
        tick(1);
        read_exp("R4 low level sets", 3, 32'h0108_0000);
        wr(7'(3*4), 32'h0108_0000);
        read_exp("R9 R4 set wins while low", 3, 32'h0108_0000);
        pin_in[3] = 1'b1; tick(4);
        read_exp("R4 sticky after high", 3, 32'h0108_0000);
        wr(7'(3*4), 32'h0108_0000);
        tick(2);
        read_exp("R4 clear stays once high", 3, 32'h0008_0000);
        push("R4 irq low", 0, 32'h0);

        // R6 DMA rising
        wr(7'(7*4), 32'h0001_0000);
        pin_in[7] = 1'b1; tick(3);
        read_exp("R6 dma rise sets", 7, 32'h0101_0000);
        push("R6 dma_req", 1, 32'h0000_0080);
        push("R6 no irq", 0, 32'h0);
        dma_done[7] = 1'b1; tick(1); dma_done[7] = 1'b0;
        read_exp("R6 done clears", 7, 32'h0001_0000);
        push("R6 dma_req low", 1, 32'h0);
        // R6 DMA falling
        wr(7'(7*4), 32'h0002_0000);
        pin_in[7] = 1'b0; tick(3);
        read_exp("R6 dma fall sets", 7, 32'h0102_0000);
        dma_done[7] = 1'b1; tick(1); dma_done[7] = 1'b0;
        // R6 DMA either edge
        wr(7'(7*4), 32'h0003_0000);
        pin_in[7] = 1'b1; tick(3);
        read_exp("R6 dma any-edge sets", 7, 32'h0103_0000);
        dma_done[7] = 1'b1; tick(1); dma_done[7] = 1'b0;
        read_exp("R6 any-edge done clears", 7, 32'h0003_0000);

        // R7 dma_done ignored by interrupt-routed pin
        wr(7'(2*4), 32'h0009_0000);
        pin_in[2] = 1'b1; tick(3);
        dma_done[2] = 1'b1; tick(1); dma_done[2] = 1'b0;
        read_exp("R7 done ignored", 2, 32'h0109_0000);
        push("R7 irq stays", 0, 32'h1);
        wr(7'(2*4), 32'h0109_0000);
        push("R7 irq after clear", 0, 32'h0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule